// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address when the translation buffer has missed. It reads two 32-bit entries from a word-addressed memory, one after the other. The first read uses the table base supplied with the request and the top bits of the virtual address. The second read uses the table frame held in the first entry and the middle bits of the virtual address. The block then checks the leaf entry's permission bits against the kind of access the requester asked for. It returns either a physical address or a fault status.

Requests are accepted one at a time. A request is taken when `req_valid` is high while `req_ready` is high. The block then owns the single memory read port until it answers with a one-cycle response pulse. The memory returns data at least one cycle after a read is issued, and it may add any number of further wait cycles.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: The first read goes to word address {base frame bits 19:0, vaddr bits 31:22}. The base frame is `pt_base` as sampled when the request is accepted.
- R3: When the first entry has bit 0 (valid) set, the second read goes to word address {first entry bits 31:12, vaddr bits 21:12}.
- R4: When the leaf entry is valid and permits the access, the response has `rsp_status` 0 and `rsp_paddr` = {leaf bits 31:12, vaddr bits 11:0}.
- R5: When the first entry has bit 0 clear, the walk ends after exactly one memory read. The response then has `rsp_status` 1 and `rsp_paddr` 0.
- R6: When the leaf entry has bit 0 clear, the walk ends after two reads with `rsp_status` 1 and `rsp_paddr` 0. This holds whatever its permission bits are.
- R7: The leaf permission bits are bit 1 (read), bit 2 (write) and bit 3 (execute). The access codes are 0 read, 1 write and 2 execute. A valid leaf that lacks the bit for the requested access gives `rsp_status` 2 and `rsp_paddr` 0. Access code 3 always gives `rsp_status` 2.
- R8: Each level issues `mem_rd_en` for exactly one cycle. `mem_addr` holds steady until `mem_rvalid` returns. Extra memory wait cycles change neither the read count nor the result.
- R9: A change of `pt_base` after a request has been accepted does not affect that walk. The new value is used by the next request.
- R10: `req_ready` is low from acceptance until the response. `req_valid` is ignored during that time. `rsp_valid` is a single-cycle pulse, and `req_ready` is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pt_base | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_addr | output | 30 | Word address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry returned by memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 success, 1 page fault, 2 protection fault |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |

## Verification
A wrong walk state shows up at the memory port first. It appears within one or two cycles of the fault, as a missing read, a repeated read, or a read at the wrong word address. It then reaches the response as a wrong status or frame. A latched base or index corrupted during a memory stall shows up in the very next `mem_addr` value. Stuck handshake state shows up as a `req_ready` that never returns, or as a response that lasts more than one cycle.

// File: rtl/pgwalk_pkg.sv
// Shared types for the page table walker.
// Assumes a 32-bit entry format with the valid flag in bit 0.
package pgwalk_pkg;

    typedef enum logic [2:0] {
        WS_IDLE    = 3'd0,
        WS_READ_L1 = 3'd1,
        WS_READ_L2 = 3'd2,
        WS_DONE    = 3'd3,
        WS_FAULT   = 3'd4
    } walk_state_t;

    typedef enum logic [1:0] {
        RS_OK    = 2'd0,
        RS_PGFLT = 2'd1,
        RS_PROT  = 2'd2
    } walk_status_t;

    localparam int unsigned ACC_KINDS = 3;   // read, write, execute

endpackage

// File: rtl/pgwalk_index.sv
// Forms the word address of the table entry for the current level.
// Assumes each table fills exactly one frame, so {frame, index} is a word address.
module pgwalk_index #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned FRM_W = 20,
    localparam int unsigned MA_W = FRM_W + IDX_W
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [FRM_W-1:0] root_frame,
    input  logic [FRM_W-1:0] leaf_tbl_frame,
    input  logic             second_level,
    output logic [MA_W-1:0]  entry_addr
);
    localparam int unsigned HI_LSB = OFF_W + IDX_W;

    logic [IDX_W-1:0] idx_top;
    logic [IDX_W-1:0] idx_mid;

    // Split the virtual address and pick the table for this level.
    always_comb begin
        idx_top = vaddr[HI_LSB +: IDX_W];
        idx_mid = vaddr[OFF_W +: IDX_W];
        if (second_level) entry_addr = {leaf_tbl_frame, idx_mid};
        else              entry_addr = {root_frame, idx_top};
    end
endmodule

// File: rtl/pgwalk_perm.sv
// Decides whether a leaf entry's permission bits allow the requested access.
// Assumes the bit order read, write, execute; unknown access codes are denied.
module pgwalk_perm #(
    parameter int unsigned KINDS = pgwalk_pkg::ACC_KINDS
) (
    input  logic [1:0]       access,
    input  logic [KINDS-1:0] perm_bits,
    output logic             allowed
);
    logic [KINDS-1:0] hit;

    // One match term per access kind.
    for (genvar k = 0; k < KINDS; k++) begin : g_kind
        assign hit[k] = (access == 2'(k)) && perm_bits[k];
    end

    assign allowed = |hit;
endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker: takes one request at a time and reads the
// top-level and leaf entries through a single read port. Assumes read data
// returns at least one cycle after the strobe, after any number of wait cycles.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned E_W   = 32,
    localparam int unsigned IDX_W = OFF_W - 2,
    localparam int unsigned FRM_W = PA_W - OFF_W,
    localparam int unsigned MA_W  = FRM_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FRM_W-1:0] pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_access,
    output logic             mem_rd_en,
    output logic [MA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [E_W-1:0]   mem_rdata,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [PA_W-1:0]  rsp_paddr
);
    walk_state_t       state_q;
    logic [VA_W-1:0]   vaddr_q;
    logic [1:0]        acc_q;
    logic [FRM_W-1:0]  base_q;
    logic [FRM_W-1:0]  l2frm_q;
    logic              issued_q;
    walk_status_t      status_q;
    logic [PA_W-1:0]   paddr_q;
    logic              perm_ok;
    logic              data_in;

    pgwalk_index #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .FRM_W(FRM_W)
    ) u_index (
        .vaddr          (vaddr_q),
        .root_frame     (base_q),
        .leaf_tbl_frame (l2frm_q),
        .second_level   (state_q == WS_READ_L2),
        .entry_addr     (mem_addr)
    );

    pgwalk_perm #(.KINDS(ACC_KINDS)) u_perm (
        .access    (acc_q),
        .perm_bits (mem_rdata[ACC_KINDS:1]),
        .allowed   (perm_ok)
    );

    // Handshake and memory strobe follow the walk state.
    assign req_ready  = (state_q == WS_IDLE);
    assign mem_rd_en  = ((state_q == WS_READ_L1) || (state_q == WS_READ_L2)) && !issued_q;
    assign data_in    = mem_rvalid && issued_q;
    assign rsp_valid  = (state_q == WS_DONE) || (state_q == WS_FAULT);
    assign rsp_status = status_q;
    assign rsp_paddr  = paddr_q;

    // Walk sequencer: latch the request, read both levels, build the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WS_IDLE;
            vaddr_q  <= '0;
            acc_q    <= '0;
            base_q   <= '0;
            l2frm_q  <= '0;
            issued_q <= 1'b0;
            status_q <= RS_OK;
            paddr_q  <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        vaddr_q  <= req_vaddr;
                        acc_q    <= req_access;
                        base_q   <= pt_base;
                        issued_q <= 1'b0;
                        state_q  <= WS_READ_L1;
                    end
                end
                WS_READ_L1: begin
                    if (mem_rd_en) issued_q <= 1'b1;
                    if (data_in) begin
                        issued_q <= 1'b0;
                        if (mem_rdata[0]) begin
                            l2frm_q <= mem_rdata[E_W-1 -: FRM_W];
                            state_q <= WS_READ_L2;
                        end else begin
                            status_q <= RS_PGFLT;
                            paddr_q  <= '0;
                            state_q  <= WS_FAULT;
                        end
                    end
                end
                WS_READ_L2: begin
                    if (mem_rd_en) issued_q <= 1'b1;
                    if (data_in) begin
                        issued_q <= 1'b0;
                        if (!mem_rdata[0]) begin
                            status_q <= RS_PGFLT;
                            paddr_q  <= '0;
                            state_q  <= WS_FAULT;
                        end else if (!perm_ok) begin
                            status_q <= RS_PROT;
                            paddr_q  <= '0;
                            state_q  <= WS_FAULT;
                        end else begin
                            status_q <= RS_OK;
                            paddr_q  <= {mem_rdata[E_W-1 -: FRM_W], vaddr_q[OFF_W-1:0]};
                            state_q  <= WS_DONE;
                        end
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    // R8: a level never strobes the read port on two consecutive cycles.
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R8: the entry address stays put while a level waits for data.
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WS_READ_L1 || state_q == WS_READ_L2) && $past(state_q) == state_q)
        |-> $stable(mem_addr));

    // R5: the second level is reached only through a valid first entry.
    a_r5_l2_needs_valid_l1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_READ_L2 && $past(state_q) == WS_READ_L1)
        |-> $past(mem_rvalid && mem_rdata[0]));

    // R10: a response lasts one cycle and the walker is ready right after it.
    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R4: a response never carries the unused status code.
    a_r4_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));
endmodule

// File: tb/sim_pgwalk_top.sv
`timescale 1ns/1ps
module sim_pgwalk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] pt_base = 20'h00010;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        mem_rd_en;
    logic [29:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_paddr;

    int nchk = 0;
    int nerr = 0;
    int wait_cfg = 0;
    int nreads = 0;
    logic [29:0] rd_log [4];
    logic [29:0] ent_a [16];
    logic [31:0] ent_d [16];
    int ent_n = 0;

    always #2 clk = ~clk;

    pgwalk_top u0 (
        .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_access(req_access),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr)
    );

    function automatic logic [31:0] lookup(input logic [29:0] a);
        logic [31:0] d = '0;
        for (int i = 0; i < ent_n; i++) if (ent_a[i] == a) d = ent_d[i];
        return d;
    endfunction

    // Memory model: one cycle of latency plus wait_cfg extra cycles.
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [29:0] paddr_pend = '0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_rd_en) begin
            rd_log[nreads % 4] <= mem_addr;
            nreads <= nreads + 1;
            if (wait_cfg == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= lookup(mem_addr);
            end else begin
                pend <= 1'b1;
                cnt <= wait_cfg - 1;
                paddr_pend <= mem_addr;
            end
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= lookup(paddr_pend);
                pend <= 1'b0;
            end else cnt <= cnt - 1;
        end
    end

    task automatic put(input logic [29:0] a, input logic [31:0] d);
        ent_a[ent_n] = a; ent_d[ent_n] = d; ent_n++;
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one request and returns its response, read count and read addresses.
    task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                        output logic [1:0] st, output logic [31:0] pa, output int nr,
                        output logic [29:0] a0, output logic [29:0] a1, output logic pulse_ok);
        int b;
        int t = 0;
        @(negedge clk);
        b = nreads;
        req_vaddr = va; req_access = acc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && t < 500) begin @(negedge clk); t++; end
        st = rsp_status; pa = rsp_paddr; nr = nreads - b;
        a0 = rd_log[b % 4]; a1 = rd_log[(b + 1) % 4];
        @(negedge clk);
        pulse_ok = !rsp_valid && req_ready;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk(mem_rd_en == 1'b0, "R1 mem_rd_en after reset", 32'(mem_rd_en), 32'd0);
    endtask

    task automatic t_success();
        logic [1:0] st; logic [31:0] pa; int nr; logic [29:0] a0, a1; logic p;
        walk(32'h00403ABC, 2'd0, st, pa, nr, a0, a1, p);
        chk(a0 == 30'h4001, "R2 first read address", 32'(a0), 32'h4001);
        chk(a1 == 30'h8003, "R3 second read address", 32'(a1), 32'h8003);
        chk(st == 2'd0, "R4 status read ok", 32'(st), 0);
        chk(pa == 32'h12345ABC, "R4 paddr", pa, 32'h12345ABC);
        chk(p, "R10 single-cycle response", 32'(p), 1);
        walk(32'h00404123, 2'd1, st, pa, nr, a0, a1, p);
        chk(st == 2'd0 && pa == 32'h0ABCD123, "R4 write on rwx page", pa, 32'h0ABCD123);
        walk(32'hFFFFFFFF, 2'd0, st, pa, nr, a0, a1, p);
        chk(a0 == 30'h43FF, "R2 top index max", 32'(a0), 32'h43FF);
        chk(a1 == 30'h3FFFFFFF, "R3 frame and index max", 32'(a1), 32'h3FFFFFFF);
        chk(st == 2'd0 && pa == 32'h00001FFF, "R4 offset max", pa, 32'h00001FFF);
    endtask

    task automatic t_page_faults();
        logic [1:0] st; logic [31:0] pa; int nr; logic [29:0] a0, a1; logic p;
        walk(32'h00800000, 2'd0, st, pa, nr, a0, a1, p);
        chk(nr == 1, "R5 one read on invalid top entry", 32'(nr), 1);
        chk(a0 == 30'h4002, "R5 read address", 32'(a0), 32'h4002);
        chk(st == 2'd1 && pa == 0, "R5 page fault status", 32'(st), 1);
        walk(32'h00406000, 2'd0, st, pa, nr, a0, a1, p);
        chk(nr == 2, "R6 two reads on invalid leaf", 32'(nr), 2);
        chk(st == 2'd1 && pa == 0, "R6 page fault despite rights", 32'(st), 1);
    endtask

    task automatic t_rights();
        logic [1:0] st; logic [31:0] pa; int nr; logic [29:0] a0, a1; logic p;
        walk(32'h00403ABC, 2'd1, st, pa, nr, a0, a1, p);
        chk(st == 2'd2 && pa == 0, "R7 write to read-only", 32'(st), 2);
        walk(32'h00403ABC, 2'd2, st, pa, nr, a0, a1, p);
        chk(st == 2'd2, "R7 execute on read-only", 32'(st), 2);
        walk(32'h00405FFF, 2'd2, st, pa, nr, a0, a1, p);
        chk(st == 2'd0 && pa == 32'h00777FFF, "R7 execute on exec-only", pa, 32'h00777FFF);
        walk(32'h00405FFF, 2'd0, st, pa, nr, a0, a1, p);
        chk(st == 2'd2, "R7 read on exec-only", 32'(st), 2);
        walk(32'h00404123, 2'd3, st, pa, nr, a0, a1, p);
        chk(st == 2'd2 && pa == 0, "R7 access code 3 denied", 32'(st), 2);
    endtask

    task automatic t_wait();
        logic [1:0] st; logic [31:0] pa; int nr; logic [29:0] a0, a1; logic p;
        wait_cfg = 4;
        walk(32'h00403ABC, 2'd0, st, pa, nr, a0, a1, p);
        chk(nr == 2, "R8 read count with wait cycles", 32'(nr), 2);
        chk(st == 2'd0 && pa == 32'h12345ABC, "R8 result with wait cycles", pa, 32'h12345ABC);
        wait_cfg = 0;
    endtask

    task automatic t_base_switch();
        logic [1:0] st; logic [31:0] pa; int b; int t = 0;
        @(negedge clk);
        b = nreads;
        req_vaddr = 32'h00403ABC; req_access = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        pt_base = 20'h00030;
        while (!rsp_valid && t < 500) begin @(negedge clk); t++; end
        chk(rd_log[b % 4] == 30'h4001, "R9 base sampled at accept", 32'(rd_log[b % 4]), 32'h4001);
        chk(rsp_paddr == 32'h12345ABC, "R9 result uses old table", rsp_paddr, 32'h12345ABC);
        @(negedge clk);
        begin
            logic [31:0] pa2; int nr; logic [29:0] a0, a1; logic p;
            walk(32'h00403ABC, 2'd0, st, pa2, nr, a0, a1, p);
            chk(a0 == 30'hC001, "R9 new base on next request", 32'(a0), 32'hC001);
            chk(pa2 == 32'h55555ABC, "R9 new table result", pa2, 32'h55555ABC);
        end
        pt_base = 20'h00010;
    endtask

    task automatic t_busy();
        int b; int t = 0; int rsps = 0; logic busy_ok = 1'b1;
        wait_cfg = 3;
        @(negedge clk);
        b = nreads;
        req_vaddr = 32'h00403ABC; req_access = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        req_vaddr = 32'h00800000;
        repeat (4) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!rsp_valid && t < 500) begin @(negedge clk); t++; end
        chk(busy_ok, "R10 req_ready low while busy", 32'(busy_ok), 1);
        chk(rsp_paddr == 32'h12345ABC, "R10 busy request ignored", rsp_paddr, 32'h12345ABC);
        repeat (20) begin @(negedge clk); if (rsp_valid) rsps++; end
        chk(rsps == 0 && nreads - b == 2, "R10 no extra walk", 32'(nreads - b), 2);
        wait_cfg = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        put(30'h4001, 32'h00020001);
        put(30'h8003, 32'h12345003);
        put(30'h8004, 32'h0ABCD00F);
        put(30'h8005, 32'h00777009);
        put(30'h8006, 32'h1234500E);
        put(30'h43FF, 32'hFFFFF001);
        put(30'h3FFFFFFF, 32'h00001003);
        put(30'hC001, 32'h00040001);
        put(30'h10003, 32'h55555003);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_success();
        t_page_faults();
        t_rights();
        t_wait();
        t_base_switch();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule